// File: doc/BRIEF.md
# Cache Hit/Miss Tracker

This block holds only the tag side of a small data cache, with tags, valid bits and a recency order for each set. It answers, in hardware, whether each reference in an address stream would hit or miss. A client presents one byte address per cycle with a valid/ready handshake. One cycle after a reference is accepted, the block reports hit or miss for it. Two saturating counters track how many references were accepted and how many of them missed.

The organisation is fixed when the block is built. The `WAYS` parameter selects direct-mapped (1), 2-way or 4-way, and `CAP_BYTES` sets the total capacity. Lines are 4 bytes, so the set count is `CAP_BYTES / (4 * WAYS)`. The block is not built to show fewer misses at higher associativity, and for some streams it will show more. The victim rule can change at run time through one input: evict the least recently used way or the most recently used way. A flush input empties the tag store and zeroes the counters in a single cycle.

Top module: `cache_trk`

## Requirements
- R1: The block number of a reference is `ref_addr >> 2` and its set is the block number modulo `CAP_BYTES/(4*WAYS)`. In an 8-byte direct-mapped build, the cyclic stream 0,4,8 gives hits only on address 4 after its first touch.
- R2: A reference is accepted on a cycle with `ref_valid` and `ref_ready` both high. `res_valid` is high for exactly the following cycle, and `res_hit` holds that reference's result.
- R3: A reference hits when a valid way of its set holds its tag. A hit leaves `miss_count` unchanged.
- R4: On a miss, the lowest-numbered invalid way of the set is filled first. A resident block then hits until it is evicted.
- R5: Each set keeps its ways ordered from most to least recent, and every hit or fill moves the touched way to most recent. With `repl_mru` = 0 (LRU), a miss in a full set evicts the least recent way. In an 8-byte 2-way build, the stream 0,4,8 repeated misses on every reference.
- R6: With `repl_mru` = 1 (MRU), a miss in a full set evicts the most recent way. In an 8-byte 2-way build, the stream 0,4,8 repeated gives the pattern miss,miss,miss,hit,miss,hit,miss,hit,miss.
- R7: `ref_count` rises by one per accepted reference and `miss_count` by one per miss. Both stop at all ones (width `CNT_W`, default 32) rather than wrapping.
- R8: While `flush` is high, `ref_ready` is low. After the flush cycle both counters read zero and every way is invalid, so a previously resident address misses.
- R9: A cycle with `ref_valid` low produces no result strobe and leaves both counters unchanged.
- R10: Address bits [1:0] are ignored. Addresses within the same 4-byte block share a line, so 3 hits after 0, and 5 hits after 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Invalidate all lines and clear both counters |
| repl_mru | input | 1 | Victim rule: 0 evicts least recent, 1 evicts most recent |
| ref_valid | input | 1 | Reference present |
| ref_ready | output | 1 | Reference can be accepted (low during flush) |
| ref_addr | input | ADDR_W | Byte address of the reference |
| res_valid | output | 1 | Result strobe, one cycle after acceptance |
| res_hit | output | 1 | 1 = hit, 0 = miss |
| ref_count | output | CNT_W | Saturating count of accepted references |
| miss_count | output | CNT_W | Saturating count of misses |

## Verification
The bench builds three copies of the block and drives them with the same stream. The first is 8 bytes direct-mapped with 4-bit counters. The second is 8 bytes with one 2-way set. The third is 16 bytes with one 4-way set. The two 8-byte builds show the three-address cycle where direct-mapped beats LRU and MRU recovers some hits. The 4-way build shows invalid-way fill order and LRU order after an intervening hit. The 4-bit counters make saturation reachable in twenty references.

// File: rtl/cache_trk_pkg.sv
package cache_trk_pkg;

  typedef enum logic {
    REPL_LRU = 1'b0,
    REPL_MRU = 1'b1
  } repl_e;

  function automatic int unsigned bits_min1(input int unsigned v);
    return (v > 1) ? $clog2(v) : 1;
  endfunction

endpackage

// File: rtl/cache_trk_way.sv
// One way of the tag store: tag array without reset, valid bits in flops.
module cache_trk_way #(
  parameter int unsigned DEPTH = 2,
  parameter int unsigned IDX_W = 1,
  parameter int unsigned TAG_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic [IDX_W-1:0] idx,
  input  logic [TAG_W-1:0] tag,
  input  logic             wr_en,
  output logic             vld,
  output logic             match
);

  logic [TAG_W-1:0] tag_mem [DEPTH];
  logic [DEPTH-1:0] vld_q;

  always_ff @(posedge clk) begin
    if (wr_en) tag_mem[idx] <= tag;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) vld_q <= '0;
    else if (wr_en) vld_q[idx] <= 1'b1;
  end

  assign vld   = vld_q[idx];
  assign match = vld_q[idx] && (tag_mem[idx] == tag);

endmodule

// File: rtl/cache_trk_recency.sv
// Per-set recency list: position 0 is most recent, last position least recent.
module cache_trk_recency #(
  parameter int unsigned WAYS  = 2,
  parameter int unsigned DEPTH = 2,
  parameter int unsigned IDX_W = 1,
  parameter int unsigned WAY_W = 1
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        clr,
  input  logic [IDX_W-1:0]            idx,
  input  logic                        touch,
  input  logic [WAY_W-1:0]            touch_way,
  output logic [WAYS-1:0][WAY_W-1:0]  order
);

  logic [WAYS-1:0][WAY_W-1:0] ord_q [DEPTH];
  logic [WAYS-1:0][WAY_W-1:0] nxt;

  assign order = ord_q[idx];

  always_comb begin
    int pos;
    pos = 0;
    for (int k = 0; k < int'(WAYS); k++) begin
      if (order[k] == touch_way) pos = k;
    end
    nxt    = order;
    nxt[0] = touch_way;
    for (int k = 1; k < int'(WAYS); k++) begin
      nxt[k] = (k <= pos) ? order[k-1] : order[k];
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      for (int s = 0; s < int'(DEPTH); s++) begin
        for (int k = 0; k < int'(WAYS); k++) begin
          ord_q[s][k] <= WAY_W'(k);
        end
      end
    end else if (touch) begin
      ord_q[idx] <= nxt;
    end
  end

endmodule

// File: rtl/cache_trk_pick.sv
// Hit detection, invalid-way fill choice and policy victim selection.
module cache_trk_pick #(
  parameter int unsigned WAYS  = 2,
  parameter int unsigned WAY_W = 1
) (
  input  logic [WAYS-1:0]             vld,
  input  logic [WAYS-1:0]             match,
  input  logic [WAYS-1:0][WAY_W-1:0]  order,
  input  cache_trk_pkg::repl_e        policy,
  output logic                        hit,
  output logic [WAY_W-1:0]            upd_way
);

  logic             free;
  logic [WAY_W-1:0] hit_way;
  logic [WAY_W-1:0] free_way;
  logic [WAY_W-1:0] evict_way;

  always_comb begin
    hit     = 1'b0;
    hit_way = '0;
    for (int w = 0; w < int'(WAYS); w++) begin
      if (vld[w] && match[w]) begin
        hit     = 1'b1;
        hit_way = WAY_W'(w);
      end
    end
  end

  always_comb begin
    free     = 1'b0;
    free_way = '0;
    for (int w = int'(WAYS) - 1; w >= 0; w--) begin
      if (!vld[w]) begin
        free     = 1'b1;
        free_way = WAY_W'(w);
      end
    end
  end

  assign evict_way = (policy == cache_trk_pkg::REPL_MRU) ? order[0] : order[WAYS-1];
  assign upd_way   = hit ? hit_way : (free ? free_way : evict_way);

endmodule

// File: rtl/cache_trk_satcnt.sv
module cache_trk_satcnt #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt
);

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (inc && (cnt != '1)) cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/cache_trk.sv
module cache_trk #(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned CAP_BYTES  = 1024,
  parameter int unsigned WAYS       = 1,
  parameter int unsigned CNT_W      = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              repl_mru,
  input  logic              ref_valid,
  output logic              ref_ready,
  input  logic [ADDR_W-1:0] ref_addr,
  output logic              res_valid,
  output logic              res_hit,
  output logic [CNT_W-1:0]  ref_count,
  output logic [CNT_W-1:0]  miss_count
);

  import cache_trk_pkg::*;

  localparam int unsigned LINE_BYTES = 4;
  localparam int unsigned OFF_W      = $clog2(LINE_BYTES);
  localparam int unsigned LINES      = CAP_BYTES / LINE_BYTES;
  localparam int unsigned SETS       = LINES / WAYS;
  localparam int unsigned IDX_BITS   = (SETS > 1) ? $clog2(SETS) : 0;
  localparam int unsigned IDX_W      = bits_min1(SETS);
  localparam int unsigned DEPTH      = 1 << IDX_W;
  localparam int unsigned WAY_W      = bits_min1(WAYS);
  localparam int unsigned BLK_W      = ADDR_W - OFF_W;
  localparam int unsigned TAG_W      = BLK_W - IDX_BITS;
  localparam logic [BLK_W-1:0] IDX_MASK = BLK_W'(SETS - 1);

  logic                       fire;
  logic [BLK_W-1:0]           blk;
  logic [IDX_W-1:0]           idx;
  logic [TAG_W-1:0]           tag;
  logic [WAYS-1:0]            way_vld;
  logic [WAYS-1:0]            way_match;
  logic [WAYS-1:0][WAY_W-1:0] order;
  logic                       hit;
  logic [WAY_W-1:0]           upd_way;
  repl_e                      policy;
  logic                       unused_off;

  assign ref_ready  = !flush;
  assign fire       = ref_valid && ref_ready;
  assign blk        = ref_addr[ADDR_W-1:OFF_W];
  assign idx        = IDX_W'(blk & IDX_MASK);
  assign tag        = TAG_W'(blk >> IDX_BITS);
  assign policy     = repl_e'(repl_mru);
  assign unused_off = ^ref_addr[OFF_W-1:0];

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    cache_trk_way #(
      .DEPTH (DEPTH),
      .IDX_W (IDX_W),
      .TAG_W (TAG_W)
    ) u_way (
      .clk   (clk),
      .rst   (rst),
      .clr   (flush),
      .idx   (idx),
      .tag   (tag),
      .wr_en (fire && !hit && (upd_way == WAY_W'(w))),
      .vld   (way_vld[w]),
      .match (way_match[w])
    );
  end

  cache_trk_recency #(
    .WAYS  (WAYS),
    .DEPTH (DEPTH),
    .IDX_W (IDX_W),
    .WAY_W (WAY_W)
  ) u_recency (
    .clk       (clk),
    .rst       (rst),
    .clr       (flush),
    .idx       (idx),
    .touch     (fire),
    .touch_way (upd_way),
    .order     (order)
  );

  cache_trk_pick #(
    .WAYS  (WAYS),
    .WAY_W (WAY_W)
  ) u_pick (
    .vld     (way_vld),
    .match   (way_match),
    .order   (order),
    .policy  (policy),
    .hit     (hit),
    .upd_way (upd_way)
  );

  cache_trk_satcnt #(.W(CNT_W)) u_ref_cnt (
    .clk (clk),
    .rst (rst),
    .clr (flush),
    .inc (fire),
    .cnt (ref_count)
  );

  cache_trk_satcnt #(.W(CNT_W)) u_miss_cnt (
    .clk (clk),
    .rst (rst),
    .clr (flush),
    .inc (fire && !hit),
    .cnt (miss_count)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_hit   <= 1'b0;
    end else begin
      res_valid <= fire;
      res_hit   <= fire && hit;
    end
  end

endmodule

// File: rtl/cache_trk_chk.sv
module cache_trk_chk #(
  parameter int unsigned CNT_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             flush,
  input logic             ref_valid,
  input logic             ref_ready,
  input logic             res_valid,
  input logic             res_hit,
  input logic [CNT_W-1:0] ref_count,
  input logic [CNT_W-1:0] miss_count
);

  AST_RESULT_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    (ref_valid && ref_ready) |=> res_valid); // R2

  AST_NO_RESULT_IDLE: assert property (@(posedge clk) disable iff (rst)
    !(ref_valid && ref_ready) |=> !res_valid); // R9

  AST_HIT_KEEPS_MISSES: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_hit) |-> (miss_count == $past(miss_count))); // R3

  AST_MISS_WITHIN_REFS: assert property (@(posedge clk) disable iff (rst)
    miss_count <= ref_count); // R7

  AST_REF_STEP: assert property (@(posedge clk) disable iff (rst)
    (ref_valid && ref_ready && (ref_count != '1)) |=> (ref_count == $past(ref_count) + 1'b1)); // R7

  AST_REF_SATURATES: assert property (@(posedge clk) disable iff (rst)
    ((ref_count == '1) && !flush) |=> (ref_count == '1)); // R7

  AST_FLUSH_STALLS: assert property (@(posedge clk) disable iff (rst)
    flush |-> !ref_ready); // R8

  AST_FLUSH_ZEROES: assert property (@(posedge clk) disable iff (rst)
    flush |=> ((ref_count == '0) && (miss_count == '0))); // R8

endmodule

bind cache_trk cache_trk_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .flush      (flush),
  .ref_valid  (ref_valid),
  .ref_ready  (ref_ready),
  .res_valid  (res_valid),
  .res_hit    (res_hit),
  .ref_count  (ref_count),
  .miss_count (miss_count)
);

// File: tb/cache_trk_bench.sv
`timescale 1ns/1ps
module cache_trk_bench;

  localparam int AW = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic flush = 1'b0;
  logic repl_mru = 1'b0;
  logic ref_valid = 1'b0;
  logic [AW-1:0] ref_addr = '0;

  logic rdy_w2, rdy_dm, rdy_w4;
  logic rv_w2, rv_dm, rv_w4;
  logic rh_w2, rh_dm, rh_w4;
  logic [31:0] rc_w2, mc_w2, rc_w4, mc_w4;
  logic [3:0]  rc_dm, mc_dm;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [AW-1:0] seq_a [16];

  always #5 clk = ~clk;

  cache_trk #(.ADDR_W(AW), .CAP_BYTES(8), .WAYS(2), .CNT_W(32)) u_cache_trk (
    .clk(clk), .rst(rst), .flush(flush), .repl_mru(repl_mru),
    .ref_valid(ref_valid), .ref_ready(rdy_w2), .ref_addr(ref_addr),
    .res_valid(rv_w2), .res_hit(rh_w2), .ref_count(rc_w2), .miss_count(mc_w2));

  cache_trk #(.ADDR_W(AW), .CAP_BYTES(8), .WAYS(1), .CNT_W(4)) u_cache_trk_dm (
    .clk(clk), .rst(rst), .flush(flush), .repl_mru(repl_mru),
    .ref_valid(ref_valid), .ref_ready(rdy_dm), .ref_addr(ref_addr),
    .res_valid(rv_dm), .res_hit(rh_dm), .ref_count(rc_dm), .miss_count(mc_dm));

  cache_trk #(.ADDR_W(AW), .CAP_BYTES(16), .WAYS(4), .CNT_W(32)) u_cache_trk_w4 (
    .clk(clk), .rst(rst), .flush(flush), .repl_mru(repl_mru),
    .ref_valid(ref_valid), .ref_ready(rdy_w4), .ref_addr(ref_addr),
    .res_valid(rv_w4), .res_hit(rh_w4), .ref_count(rc_w4), .miss_count(mc_w4));

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int count_miss(input string s);
    int n = 0;
    for (int i = 0; i < s.len(); i++) if (s[i] == "M") n++;
    return n;
  endfunction

  task automatic do_flush();
    @(negedge clk);
    flush = 1'b1;
    #1;
    chk(!rdy_w2 && !rdy_dm && !rdy_w4, "R8", "ready during flush", rdy_w2, 0);
    @(negedge clk);
    flush = 1'b0;
  endtask

  task automatic do_ref(input logic [AW-1:0] a, input string req,
                        output logic h_dm, output logic h_w2, output logic h_w4);
    @(negedge clk);
    ref_valid = 1'b1;
    ref_addr  = a;
    @(negedge clk);
    ref_valid = 1'b0;
    chk(rv_dm && rv_w2 && rv_w4, req, "result strobe", {rv_dm, rv_w2, rv_w4}, 7);
    h_dm = rh_dm;
    h_w2 = rh_w2;
    h_w4 = rh_w4;
  endtask

  // Expected strings: one char per reference, H = hit, M = miss.
  task automatic run_seq(input string req, input string e_dm, input string e_w2,
                         input string e_w4);
    logic h_dm, h_w2, h_w4;
    int n;
    int bad;
    n = e_dm.len();
    do_flush();
    bad = 0;
    for (int i = 0; i < n; i++) begin
      do_ref(seq_a[i], req, h_dm, h_w2, h_w4);
      if (h_dm != (e_dm[i] == "H")) begin
        bad++;
        $display("FAIL %s dm ref %0d addr %0d: actual=%0d expected=%0d",
                 req, i, seq_a[i], h_dm, e_dm[i] == "H");
      end
      if (h_w2 != (e_w2[i] == "H")) begin
        bad++;
        $display("FAIL %s 2way ref %0d addr %0d: actual=%0d expected=%0d",
                 req, i, seq_a[i], h_w2, e_w2[i] == "H");
      end
      if (h_w4 != (e_w4[i] == "H")) begin
        bad++;
        $display("FAIL %s 4way ref %0d addr %0d: actual=%0d expected=%0d",
                 req, i, seq_a[i], h_w4, e_w4[i] == "H");
      end
    end
    checks++;
    if (bad != 0) errors++;
    chk(rc_dm == 4'(n) && rc_w2 == n && rc_w4 == n, "R7", "ref counts", rc_w2, n);
    chk(mc_dm == 4'(count_miss(e_dm)), req, "dm misses", mc_dm, count_miss(e_dm));
    chk(mc_w2 == count_miss(e_w2), req, "2way misses", mc_w2, count_miss(e_w2));
    chk(mc_w4 == count_miss(e_w4), req, "4way misses", mc_w4, count_miss(e_w4));
  endtask

  task automatic t_reset();
    chk(!rv_dm && !rv_w2 && !rv_w4, "R2", "no strobe after reset", rv_w2, 0);
    chk(rc_dm == 0 && rc_w2 == 0 && rc_w4 == 0, "R7", "ref count after reset", rc_w2, 0);
    chk(mc_dm == 0 && mc_w2 == 0 && mc_w4 == 0, "R7", "miss count after reset", mc_w2, 0);
    chk(rdy_dm && rdy_w2 && rdy_w4, "R2", "ready after reset", rdy_w2, 1);
  endtask

  task automatic t_cyc3_lru();
    repl_mru = 1'b0;
    for (int i = 0; i < 9; i++) seq_a[i] = AW'((i % 3) * 4);
    // R1 direct-mapped keeps 4, R5 LRU misses all, R4 4-way fills free ways
    run_seq("R5", "MMMMHMMHM", "MMMMMMMMM", "MMMHHHHHH");
  endtask

  task automatic t_cyc3_mru();
    repl_mru = 1'b1;
    for (int i = 0; i < 9; i++) seq_a[i] = AW'((i % 3) * 4);
    run_seq("R6", "MMMMHMMHM", "MMMHMHMHM", "MMMHHHHHH");
    repl_mru = 1'b0;
  endtask

  task automatic t_cyc5_lru();
    repl_mru = 1'b0;
    for (int i = 0; i < 10; i++) seq_a[i] = AW'((i % 5) * 4);
    run_seq("R5", "MMMMMMMMMM", "MMMMMMMMMM", "MMMMMMMMMM");
  endtask

  task automatic t_cyc5_mru();
    repl_mru = 1'b1;
    for (int i = 0; i < 10; i++) seq_a[i] = AW'((i % 5) * 4);
    run_seq("R6", "MMMMMMMMMM", "MMMMMHMMMH", "MMMMMHHHMH");
    repl_mru = 1'b0;
  endtask

  task automatic t_lru_order();
    repl_mru = 1'b0;
    seq_a[0] = 0; seq_a[1] = 4; seq_a[2] = 8; seq_a[3] = 12;
    seq_a[4] = 0; seq_a[5] = 16; seq_a[6] = 4; seq_a[7] = 0;
    // 4-way: hit on 0 protects it, 16 evicts 4, then 4 evicts 8, 0 still hits
    run_seq("R5", "MMMMMMMM", "MMMMMMMM", "MMMMHMMH");
  endtask

  task automatic t_offset();
    seq_a[0] = 0; seq_a[1] = 3; seq_a[2] = 6; seq_a[3] = 5;
    run_seq("R10", "MHMH", "MHMH", "MHMH");
  endtask

  task automatic t_idle();
    logic [31:0] r0, m0;
    r0 = rc_w2;
    m0 = mc_w2;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(!rv_dm && !rv_w2 && !rv_w4, "R9", "no strobe when idle", rv_w2, 0);
    end
    chk(rc_w2 == r0 && mc_w2 == m0 && rc_dm == 4'(r0), "R9", "counts held when idle", rc_w2, r0);
  endtask

  task automatic t_flush();
    logic h_dm, h_w2, h_w4;
    do_flush();
    chk(rc_dm == 0 && rc_w2 == 0 && rc_w4 == 0, "R8", "ref count after flush", rc_w2, 0);
    chk(mc_dm == 0 && mc_w2 == 0 && mc_w4 == 0, "R8", "miss count after flush", mc_w2, 0);
    do_ref(AW'(0), "R8", h_dm, h_w2, h_w4);
    chk(!h_dm && !h_w2 && !h_w4, "R8", "resident address misses after flush",
        {h_dm, h_w2, h_w4}, 0);
  endtask

  task automatic t_sat();
    logic h_dm, h_w2, h_w4;
    do_flush();
    for (int i = 0; i < 20; i++) do_ref(AW'(0), "R7", h_dm, h_w2, h_w4);
    chk(h_dm && h_w2 && h_w4, "R4", "resident block keeps hitting", {h_dm, h_w2, h_w4}, 7);
    chk(rc_dm == 4'hF, "R7", "4-bit ref count saturates", rc_dm, 15);
    chk(mc_dm == 4'd1, "R7", "4-bit miss count", mc_dm, 1);
    chk(rc_w2 == 20 && mc_w2 == 1, "R7", "32-bit ref count", rc_w2, 20);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_cyc3_lru();
    t_cyc3_mru();
    t_cyc5_lru();
    t_cyc5_mru();
    t_lru_order();
    t_offset();
    t_idle();
    t_flush();
    t_sat();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule